// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This controller services a cache miss by streaming one cache line in from memory and writing it, word by word, into the cache data array. When a miss is accepted it issues a single burst request for the line. In the default mode the burst begins at the word that missed and wraps past the end of the line back to word 0. In the alternative ascending mode the burst always begins at word 0. In both modes the word the CPU wanted is returned to it on the very beat it arrives, so the CPU can resume while the rest of the line is still arriving.

While the fill is in progress the controller keeps a copy of the line and a per-word arrival bit. Once the CPU has been released, a read to the line being filled is answered straight from that copy if the word is already present, and is stalled if it is not. A read to any other line is stalled until the fill ends. The line's tag and valid bit are written to the tag array only on the last beat, so a partly filled line can never look like a complete hit.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: With the controller idle, a cycle with `miss_valid` high raises `mem_req_valid` in that same cycle, with `mem_req_line` equal to `miss_addr[ADDR_W-1:3]` and, when `miss_early` is 0, `mem_req_start` equal to `miss_addr[2:0]`; `busy` is high from the next cycle.
- R2: When `miss_early` is 1 at acceptance, `mem_req_start` is 0.
- R3: The k-th beat of the burst (k = 0..7) raises `fill_we` in its own cycle with `fill_idx` = (start + k) mod 8 and `fill_data` equal to `mem_beat_data`, so the order wraps from word 7 to word 0.
- R4: On the beat whose index equals the missed word offset, `cpu_ret_valid` is high in that cycle and `cpu_ret_data` equals `mem_beat_data`; on other beats with no CPU read, `cpu_ret_valid` is low.
- R5: After the missed word has been returned, a CPU read to the same line whose word has already arrived gets `cpu_ret_valid` high, `cpu_stall` low and the word's data, in the same cycle.
- R6: After the missed word has been returned, a CPU read to the same line whose word has not yet arrived gets `cpu_stall` high and `cpu_ret_valid` low.
- R7: During a fill, a CPU read to a different line stalls.
- R8: `tag_we` is high only in the cycle of the eighth beat, with `tag_line` equal to the line address; `busy` is low in the following cycle.
- R9: `miss_valid` while busy produces no request, and beats while idle produce no `fill_we`; when idle a CPU read is never stalled by this block.
- R10: During a fill and before the missed word has been returned, every CPU read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss to be serviced |
| miss_addr | input | ADDR_W | Word address of the miss |
| miss_early | input | 1 | 1: ascending order from word 0; 0: start at the missed word |
| mem_req_valid | output | 1 | Burst request pulse |
| mem_req_line | output | ADDR_W-3 | Line address of the burst |
| mem_req_start | output | 3 | First word index of the burst |
| mem_beat_valid | input | 1 | Memory beat present |
| mem_beat_data | input | DATA_W | Memory beat word |
| cpu_rd_valid | input | 1 | CPU read during a fill |
| cpu_rd_addr | input | ADDR_W | CPU read word address |
| cpu_ret_valid | output | 1 | Word returned to the CPU |
| cpu_ret_data | output | DATA_W | Returned word |
| cpu_stall | output | 1 | CPU read must wait |
| fill_we | output | 1 | Data array write strobe |
| fill_idx | output | 3 | Word index within the line |
| fill_data | output | DATA_W | Word written |
| tag_we | output | 1 | Tag and line-valid write strobe |
| tag_line | output | ADDR_W-3 | Line address written with the tag |
| busy | output | 1 | Fill in progress |

## Verification
The assertions assume memory delivers exactly eight beats per request and none outside a fill, and that the CPU does not issue a read in the same cycle as a beat; the bench keeps to this by spacing beats with read-probe cycles and by sending a stray beat only while the controller is idle. Under that contract the checker tracks the expected wrap index and beat count from the request port alone. The bench sweeps every missed offset in both fetch modes and, between beats, probes every word of the line plus one foreign line.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  // Word index k beats into a burst that began at start (words is a power of 2).
  function automatic int unsigned wrap_idx(int unsigned start, int unsigned k,
                                           int unsigned words);
    return (start + k) & (words - 1);
  endfunction

  // Start of the burst for a given mode.
  function automatic int unsigned first_idx(int unsigned offset, bit ascending);
    return ascending ? 0 : offset;
  endfunction
endpackage

// File: rtl/cwf_seq.sv
module cwf_seq #(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic             miss_early,
  input  logic             beat_valid,
  output logic             busy,
  output logic             accept,
  output logic [OFF_W-1:0] req_start,
  output logic             beat_fire,
  output logic [OFF_W-1:0] beat_idx,
  output logic             last_beat,
  output logic             crit_hit,
  output logic             released,
  output logic [TAG_W-1:0] line
);
  import cwf_pkg::*;

  logic             busy_q, rel_q;
  logic [OFF_W-1:0] start_q, cnt_q, crit_q;
  logic [TAG_W-1:0] line_q;

  assign accept    = !busy_q && miss_valid;
  assign req_start = OFF_W'(first_idx(32'(miss_addr[OFF_W-1:0]), miss_early));
  assign beat_fire = busy_q && beat_valid;
  assign beat_idx  = OFF_W'(wrap_idx(32'(start_q), 32'(cnt_q), LINE_WORDS));
  assign last_beat = beat_fire && (cnt_q == OFF_W'(LINE_WORDS - 1));
  assign crit_hit  = beat_fire && (beat_idx == crit_q);
  assign busy      = busy_q;
  assign released  = rel_q;
  assign line      = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rel_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
      crit_q  <= '0;
      line_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      rel_q   <= 1'b0;
      start_q <= req_start;
      cnt_q   <= '0;
      crit_q  <= miss_addr[OFF_W-1:0];
      line_q  <= miss_addr[ADDR_W-1:OFF_W];
    end else if (beat_fire) begin
      cnt_q <= cnt_q + 1'b1;
      if (crit_hit)  rel_q  <= 1'b1;
      if (last_beat) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_present
);
  logic [DATA_W-1:0]     words [LINE_WORDS];
  logic [LINE_WORDS-1:0] present;

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || clear) present[i] <= 1'b0;
      else if (wr_en && wr_idx == OFF_W'(i)) present[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == OFF_W'(i)) words[i] <= wr_data;
    end
  end

  assign rd_data    = words[rd_idx];
  assign rd_present = present[rd_idx];
endmodule

// File: rtl/cwf_cpu_port.sv
module cwf_cpu_port #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic              busy,
  input  logic              released,
  input  logic [TAG_W-1:0]  line,
  input  logic              crit_hit,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              buf_present,
  input  logic [DATA_W-1:0] buf_data,
  output logic [OFF_W-1:0]  rd_idx,
  output logic              served,
  output logic              ret_valid,
  output logic [DATA_W-1:0] ret_data,
  output logic              stall
);
  logic same_line;

  assign rd_idx    = rd_addr[OFF_W-1:0];
  assign same_line = rd_addr[ADDR_W-1:OFF_W] == line;
  // The critical forward owns the return port in its cycle.
  assign served    = busy && rd_valid && released && same_line && buf_present && !crit_hit;
  assign stall     = busy && rd_valid && !served;
  assign ret_valid = crit_hit || served;
  assign ret_data  = crit_hit ? beat_data : buf_data;
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              miss_early,
  output logic              mem_req_valid,
  output logic [TAG_W-1:0]  mem_req_line,
  output logic [OFF_W-1:0]  mem_req_start,
  input  logic              mem_beat_valid,
  input  logic [DATA_W-1:0] mem_beat_data,
  input  logic              cpu_rd_valid,
  input  logic [ADDR_W-1:0] cpu_rd_addr,
  output logic              cpu_ret_valid,
  output logic [DATA_W-1:0] cpu_ret_data,
  output logic              cpu_stall,
  output logic              fill_we,
  output logic [OFF_W-1:0]  fill_idx,
  output logic [DATA_W-1:0] fill_data,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_line,
  output logic              busy
);
  // Named internal events, visible to the bound checker.
  logic              ev_accept, ev_beat, ev_last, ev_crit, ev_released, ev_served;
  logic [OFF_W-1:0]  beat_idx, req_start, rd_idx;
  logic [TAG_W-1:0]  line;
  logic [DATA_W-1:0] buf_data;
  logic              buf_present;

  cwf_seq #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_early(miss_early), .beat_valid(mem_beat_valid), .busy(busy),
    .accept(ev_accept), .req_start(req_start), .beat_fire(ev_beat),
    .beat_idx(beat_idx), .last_beat(ev_last), .crit_hit(ev_crit),
    .released(ev_released), .line(line)
  );

  cwf_line_buf #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(ev_accept), .wr_en(ev_beat),
    .wr_idx(beat_idx), .wr_data(mem_beat_data), .rd_idx(rd_idx),
    .rd_data(buf_data), .rd_present(buf_present)
  );

  cwf_cpu_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_cpu (
    .busy(busy), .released(ev_released), .line(line), .crit_hit(ev_crit),
    .beat_data(mem_beat_data), .rd_valid(cpu_rd_valid), .rd_addr(cpu_rd_addr),
    .buf_present(buf_present), .buf_data(buf_data), .rd_idx(rd_idx),
    .served(ev_served), .ret_valid(cpu_ret_valid), .ret_data(cpu_ret_data),
    .stall(cpu_stall)
  );

  assign mem_req_valid = ev_accept;
  assign mem_req_line  = miss_addr[ADDR_W-1:OFF_W];
  assign mem_req_start = req_start;
  assign fill_we       = ev_beat;
  assign fill_idx      = beat_idx;
  assign fill_data     = mem_beat_data;
  assign tag_we        = ev_last;
  assign tag_line      = line;
endmodule

// File: rtl/cwf_fill_chk.sv
module cwf_fill_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic [OFF_W-1:0]  mem_req_start,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              cpu_rd_valid,
  input logic              cpu_ret_valid,
  input logic [DATA_W-1:0] cpu_ret_data,
  input logic              cpu_stall,
  input logic              fill_we,
  input logic [OFF_W-1:0]  fill_idx,
  input logic [DATA_W-1:0] fill_data,
  input logic              tag_we
);
  logic [OFF_W-1:0] exp_idx, beats, crit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_idx <= '0;
      beats   <= '0;
      crit    <= '0;
    end else if (mem_req_valid) begin
      exp_idx <= mem_req_start;
      beats   <= '0;
      crit    <= miss_addr[OFF_W-1:0];
    end else if (fill_we) begin
      exp_idx <= exp_idx + 1'b1;
      beats   <= beats + 1'b1;
    end
  end

  assert_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !busy);
  assert_busy_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> busy);
  assert_wrap_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> fill_idx == exp_idx);
  assert_crit_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && fill_idx == crit) |-> (cpu_ret_valid && cpu_ret_data == fill_data));
  assert_ret_or_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ret_valid && cpu_stall));
  assert_stall_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (cpu_rd_valid && busy));
  assert_tag_last_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> (fill_we && beats == OFF_W'(LINE_WORDS - 1)));
  assert_idle_after_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> !busy);
  assert_no_fill_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> busy);
endmodule

bind cwf_fill_ctrl cwf_fill_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_start(mem_req_start), .miss_addr(miss_addr), .cpu_rd_valid(cpu_rd_valid),
  .cpu_ret_valid(cpu_ret_valid), .cpu_ret_data(cpu_ret_data), .cpu_stall(cpu_stall),
  .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data), .tag_we(tag_we)
);

// File: tb/cwf_fill_ctrl_test.sv
module cwf_fill_ctrl_test;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int NW = 8;
  localparam int TW = AW - 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0, miss_early = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          mem_req_valid;
  logic [TW-1:0] mem_req_line;
  logic [2:0]    mem_req_start;
  logic          mem_beat_valid = 1'b0;
  logic [DW-1:0] mem_beat_data = '0;
  logic          cpu_rd_valid = 1'b0;
  logic [AW-1:0] cpu_rd_addr = '0;
  logic          cpu_ret_valid, cpu_stall, fill_we, tag_we, busy;
  logic [DW-1:0] cpu_ret_data, fill_data;
  logic [2:0]    fill_idx;
  logic [TW-1:0] tag_line;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cwf_fill_ctrl uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_early(miss_early), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_req_start(mem_req_start), .mem_beat_valid(mem_beat_valid),
    .mem_beat_data(mem_beat_data), .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr),
    .cpu_ret_valid(cpu_ret_valid), .cpu_ret_data(cpu_ret_data), .cpu_stall(cpu_stall),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data), .tag_we(tag_we),
    .tag_line(tag_line), .busy(busy)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(int line, int idx, int mode);
    return DW'(32'h5A000000 ^ (line << 8) ^ (mode << 4) ^ idx);
  endfunction

  task automatic quiet();
    miss_valid = 1'b0; mem_beat_valid = 1'b0; cpu_rd_valid = 1'b0;
  endtask

  task automatic run_fill(int mode, int off);
    int line, start, crit_pos;
    line     = ((mode * 8 + off) * 37 + 5) & ((1 << TW) - 1);
    start    = mode ? 0 : off;
    crit_pos = (off - start) & (NW - 1);

    // Miss acceptance
    @(negedge clk); quiet();
    miss_valid = 1'b1; miss_early = 1'(mode); miss_addr = AW'((line << 3) | off);
    #1;
    check(mem_req_valid == 1'b1, "R1 req", longint'(mem_req_valid), 1);
    check(mem_req_line == TW'(line), "R1 line", longint'(mem_req_line), longint'(line));
    check(mem_req_start == 3'(start), mode ? "R2 start" : "R1 start",
          longint'(mem_req_start), longint'(start));

    // Second miss while busy, plus a read before release
    @(negedge clk); quiet();
    miss_valid = 1'b1; miss_addr = AW'(((line ^ 1) << 3) | off);
    cpu_rd_valid = 1'b1; cpu_rd_addr = AW'((line << 3) | off);
    #1;
    check(busy == 1'b1, "R1 busy", longint'(busy), 1);
    check(mem_req_valid == 1'b0, "R9 req while busy", longint'(mem_req_valid), 0);
    check(cpu_stall == 1'b1 && cpu_ret_valid == 1'b0, "R10 early read",
          longint'(cpu_stall), 1);

    for (int k = 0; k < NW; k++) begin
      int idx;
      idx = (start + k) & (NW - 1);
      @(negedge clk); quiet();
      mem_beat_valid = 1'b1; mem_beat_data = word_of(line, idx, mode);
      #1;
      check(fill_we && fill_idx == 3'(idx), "R3 index", longint'(fill_idx), longint'(idx));
      check(fill_data == word_of(line, idx, mode), "R3 data",
            longint'(fill_data), longint'(word_of(line, idx, mode)));
      check(cpu_ret_valid == (idx == off), "R4 forward",
            longint'(cpu_ret_valid), longint'(idx == off));
      if (idx == off)
        check(cpu_ret_data == word_of(line, idx, mode), "R4 data",
              longint'(cpu_ret_data), longint'(word_of(line, idx, mode)));
      check(tag_we == (k == NW - 1), "R8 tag strobe", longint'(tag_we), longint'(k == NW - 1));
      if (k == NW - 1)
        check(tag_line == TW'(line), "R8 tag line", longint'(tag_line), longint'(line));

      if (k < NW - 1) begin
        for (int w = 0; w < NW; w++) begin
          bit rel, got;
          rel = crit_pos <= k;
          got = ((w - start) & (NW - 1)) <= k;
          @(negedge clk); quiet();
          cpu_rd_valid = 1'b1; cpu_rd_addr = AW'((line << 3) | w);
          #1;
          if (!rel)
            check(cpu_stall && !cpu_ret_valid, "R10 before release",
                  longint'(cpu_stall), 1);
          else if (got)
            check(!cpu_stall && cpu_ret_valid && cpu_ret_data == word_of(line, w, mode),
                  "R5 arrived word", longint'(cpu_ret_data),
                  longint'(word_of(line, w, mode)));
          else
            check(cpu_stall && !cpu_ret_valid, "R6 missing word", longint'(cpu_stall), 1);
        end
        @(negedge clk); quiet();
        cpu_rd_valid = 1'b1; cpu_rd_addr = AW'(((line ^ 3) << 3) | off);
        #1;
        check(cpu_stall && !cpu_ret_valid, "R7 other line", longint'(cpu_stall), 1);
      end
    end

    // After the last beat
    @(negedge clk); quiet();
    mem_beat_valid = 1'b1; mem_beat_data = 32'hDEAD;
    cpu_rd_valid = 1'b1; cpu_rd_addr = AW'((line << 3) | off);
    #1;
    check(busy == 1'b0, "R8 idle after tag", longint'(busy), 0);
    check(fill_we == 1'b0, "R9 beat while idle", longint'(fill_we), 0);
    check(cpu_stall == 1'b0, "R9 no stall idle", longint'(cpu_stall), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    check(busy == 1'b0 && fill_we == 1'b0 && tag_we == 1'b0, "R8 reset state",
          longint'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int mode = 0; mode < 2; mode++)
      for (int off = 0; off < NW; off++)
        run_fill(mode, off);
    @(negedge clk); quiet();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule